// File: doc/BRIEF.md
# Programmable Watchdog Timer with Status LED Patterns

This block is a watchdog for a system controller. A host programs it through a small register port. Writing a non-zero 8-bit timeout value arms a down-counter. The counter steps once per second, or once per minute when minute mode is selected. When it reaches zero, the block emits a one-cycle expiry pulse and sets a sticky status flag. Writing zero stops the watchdog. Reading the timeout address returns the live count, not the value that was written.

Timing comes from an external half-second strobe. Two strobes make one second, and a parameter sets how many seconds make one minute. Rising edges on the mouse and keyboard interrupt inputs can each restart a running countdown from the last non-zero value written, when that source is enabled. A rising edge on the keyboard-reset input can force an immediate expiry. All three inputs are asynchronous and are synchronised inside the block. The same mode register that sets the count unit also selects one of four patterns for a power-LED pin: released, held low, a 1 Hz square wave, or a 0.25 Hz square wave.

Top module: `wdt_led_ctrl`

## Requirements
- R1: After reset, reads at address 0 (mode), 1 (timeout count) and 2 (control) return 0x00, `led_oe` is low and `wdt_expire` is low. The mode register keeps only bits 7, 6, 3 and 2 and reads 0 in the others. The control register stores bits 7:6 and reports the sticky status in bit 4.
- R2: Writing a non-zero N to address 1 while mode bit 3 is 0 makes `wdt_expire` pulse after exactly 2N half-second strobes. In between, address 1 reads N minus the number of whole seconds elapsed.
- R3: With mode bit 3 set, each decrement takes TICKS_PER_MIN seconds, so expiry comes after 2·TICKS_PER_MIN·N strobes. The second and minute prescalers clear whenever the counter is loaded or reloaded.
- R4: Writing 0x00 to address 1 stops the countdown. The count reads 0 and no expiry occurs, however many strobes follow.
- R5: With control bit 7 (mouse) or bit 6 (keyboard) set, a rising edge on that interrupt input reloads the last non-zero value written and restarts the countdown from there. This happens only while the count is non-zero.
- R6: With the enable bit for a source clear, that interrupt input leaves the count unchanged.
- R7: Once the count is zero it stays zero until address 1 is rewritten. Interrupt edges do not restart it, and further strobes produce no further expiry.
- R8: `wdt_expire` is always a single-cycle pulse. Control bit 4 is set on every expiry and is cleared by a non-zero write to address 1.
- R9: With mode bit 2 set, a rising edge on `kbd_rst_in` forces an expiry pulse, clears the count to 0 and sets the status bit.
- R10: With mode bit 2 clear, `kbd_rst_in` has no effect on the count or on `wdt_expire`.
- R11: Mode bits 7:6 = 00 deassert `led_oe`. Bits 7:6 = 01 assert `led_oe` and drive `led_out` low.
- R12: Mode bits 7:6 = 10 toggle `led_out` on every strobe, giving 1 Hz. Mode bits 7:6 = 11 toggle it once every four strobes, giving 0.25 Hz. `led_oe` is high in both modes.
- R13: The interrupt and keyboard-reset inputs pass through two synchroniser flops. An input held high produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 timeout, 2 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| half_sec_tick | input | 1 | One-cycle strobe every half second |
| mouse_irq | input | 1 | Asynchronous mouse interrupt level |
| kbd_irq | input | 1 | Asynchronous keyboard interrupt level |
| kbd_rst_in | input | 1 | Asynchronous keyboard-reset request |
| wdt_expire | output | 1 | One-cycle timeout pulse |
| led_out | output | 1 | Power-LED data |
| led_oe | output | 1 | Power-LED output enable |

## Verification
The countdown is swept across several timeout values in seconds and across two in minutes. Each run checks both the cycle of expiry and the live count one strobe before it, which separates an off-by-one in the strobe division from an error in the count itself. The reload inputs are tried with each source enabled, with each disabled, with the counter already expired, and with an input held high. These cases tell a level-sensitive reload apart from an edge-sensitive one. The LED check counts output flips over a fixed run of strobes in every mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    LED_RELEASE = 2'b00,
    LED_LOW     = 2'b01,
    LED_FAST    = 2'b10,
    LED_SLOW    = 2'b11
  } led_mode_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_TMO  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam logic [7:0] MODE_KEEP_MASK = 8'hCC;

  // A decrement is due at a second boundary when counting in seconds,
  // or when the minute prescaler has reached its last second.
  function automatic logic f_step_due(input logic min_mode, input int unsigned pre,
                                      input int unsigned ticks_per_min);
    return (!min_mode) || (pre == ticks_per_min - 1);
  endfunction

  // Number of strobes the 0.25 Hz divider counts before toggling.
  function automatic int unsigned f_slow_div(input int unsigned fast_div);
    return fast_div * 4;
  endfunction

endpackage

// File: rtl/wdt_sync_edge.sv
module wdt_sync_edge #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] rise
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        s1_q   <= async_in[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign rise[g] = s2_q & ~prev_q;

    // R13: a held level yields one event only
    a_r13_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end

endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
  import wdt_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int TICKS_PER_MIN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_req,
  input  logic             force_req,
  input  logic             half_tick,
  input  logic             min_mode,
  input  logic             clr_status,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             sticky
);

  localparam int PRE_W = (TICKS_PER_MIN > 1) ? $clog2(TICKS_PER_MIN) : 1;

  logic [CNT_W-1:0] cnt_q, last_q;
  logic [PRE_W-1:0] pre_q;
  logic             half_ph_q, expire_q, sticky_q;

  // Named internal events
  logic running, sec_edge, step_evt, hit_zero, reload_ok;
  assign running   = (cnt_q != '0);
  assign reload_ok = reload_req && running;
  assign sec_edge  = half_tick && running && half_ph_q;
  assign step_evt  = sec_edge && f_step_due(min_mode, int'(pre_q), TICKS_PER_MIN);
  assign hit_zero  = step_evt && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      last_q    <= '0;
      pre_q     <= '0;
      half_ph_q <= 1'b0;
      expire_q  <= 1'b0;
      sticky_q  <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load_en) begin
        cnt_q     <= load_val;
        pre_q     <= '0;
        half_ph_q <= 1'b0;
        if (load_val != '0) last_q <= load_val;
        if (clr_status) sticky_q <= 1'b0;
      end else if (force_req) begin
        cnt_q    <= '0;
        expire_q <= 1'b1;
        sticky_q <= 1'b1;
      end else if (reload_ok) begin
        cnt_q     <= last_q;
        pre_q     <= '0;
        half_ph_q <= 1'b0;
      end else if (half_tick && running) begin
        half_ph_q <= ~half_ph_q;
        if (step_evt) begin
          cnt_q <= cnt_q - CNT_W'(1);
          pre_q <= '0;
          if (hit_zero) begin
            expire_q <= 1'b1;
            sticky_q <= 1'b1;
          end
        end else if (sec_edge) begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end
    end
  end

  assign cnt    = cnt_q;
  assign expire = expire_q;
  assign sticky = sticky_q;

  // R2: an undisturbed step lowers the count by exactly one
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_en && !force_req && !reload_ok) |=> (cnt_q + CNT_W'(1) == $past(cnt_q)));
  // R7: zero holds until a write
  a_r7_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_en) |=> !running);
  // R8: pulse is single-cycle and always leaves the status set
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
  a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> sticky_q);
  // R9: forced event empties the counter
  a_r9_force_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (force_req && !load_en) |=> (expire_q && cnt_q == '0));

endmodule

// File: rtl/wdt_led_gen.sv
module wdt_led_gen
  import wdt_pkg::*;
#(
  parameter int FAST_DIV = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      half_tick,
  input  led_mode_e mode,
  output logic      led_out,
  output logic      led_oe
);

  localparam int SLOW_DIV = f_slow_div(FAST_DIV);
  localparam int DIV_W    = $clog2(SLOW_DIV);

  logic [DIV_W-1:0] div_q;
  logic             fast_q, slow_q, out_q, oe_q;
  logic             fast_flip, slow_flip;

  assign fast_flip = half_tick && ((int'(div_q) % FAST_DIV) == FAST_DIV - 1);
  assign slow_flip = half_tick && (int'(div_q) == SLOW_DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      if (half_tick) div_q <= slow_flip ? '0 : div_q + DIV_W'(1);
      if (fast_flip) fast_q <= ~fast_q;
      if (slow_flip) slow_q <= ~slow_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= (mode != LED_RELEASE);
      unique case (mode)
        LED_FAST: out_q <= fast_flip ? ~fast_q : fast_q;
        LED_SLOW: out_q <= slow_flip ? ~slow_q : slow_q;
        default:  out_q <= 1'b0;
      endcase
    end
  end

  assign led_out = out_q;
  assign led_oe  = oe_q;

  // R11: released pin in mode 00
  a_r11_release_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_RELEASE) |=> !led_oe);
  // R11: low level in mode 01
  a_r11_low_level: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LED_LOW) |=> (led_oe && !led_out));
  // R12: output only moves on a strobe
  a_r12_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!half_tick && mode == $past(mode) && (mode == LED_FAST || mode == LED_SLOW)) |=> $stable(led_out));

endmodule

// File: rtl/wdt_led_ctrl.sv
module wdt_led_ctrl
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             half_sec_tick,
  input  logic             mouse_irq,
  input  logic             kbd_irq,
  input  logic             kbd_rst_in,
  output logic             wdt_expire,
  output logic             led_out,
  output logic             led_oe
);

  localparam int N_ASYNC = 3;
  localparam int I_MOUSE = 0;
  localparam int I_KBD   = 1;
  localparam int I_KRST  = 2;

  logic [7:0]       mode_q;
  logic [1:0]       reload_en_q;
  logic [N_ASYNC-1:0] rise;
  logic [CNT_W-1:0] cnt;
  logic             sticky;

  // Named decoded events
  logic wr_mode, wr_tmo, wr_ctrl, reload_req, force_req, min_mode;
  assign wr_mode    = reg_we && (reg_addr == ADDR_MODE);
  assign wr_tmo     = reg_we && (reg_addr == ADDR_TMO);
  assign wr_ctrl    = reg_we && (reg_addr == ADDR_CTRL);
  assign reload_req = (rise[I_MOUSE] && reload_en_q[1]) || (rise[I_KBD] && reload_en_q[0]);
  assign force_req  = rise[I_KRST] && mode_q[2];
  assign min_mode   = mode_q[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= '0;
      reload_en_q <= '0;
    end else begin
      if (wr_mode) mode_q <= reg_wdata[7:0] & MODE_KEEP_MASK;
      if (wr_ctrl) reload_en_q <= reg_wdata[7:6];
    end
  end

  wdt_sync_edge #(.WIDTH(N_ASYNC)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({kbd_rst_in, kbd_irq, mouse_irq}),
    .rise     (rise)
  );

  wdt_count_core #(.CNT_W(CNT_W), .TICKS_PER_MIN(TICKS_PER_MIN)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (wr_tmo),
    .load_val   (reg_wdata),
    .reload_req (reload_req),
    .force_req  (force_req),
    .half_tick  (half_sec_tick),
    .min_mode   (min_mode),
    .clr_status (reg_wdata != '0),
    .cnt        (cnt),
    .expire     (wdt_expire),
    .sticky     (sticky)
  );

  wdt_led_gen #(.FAST_DIV(1)) led_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_tick (half_sec_tick),
    .mode      (led_mode_e'(mode_q[7:6])),
    .led_out   (led_out),
    .led_oe    (led_oe)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_MODE: reg_rdata[7:0] = mode_q;
      ADDR_TMO:  reg_rdata = cnt;
      ADDR_CTRL: reg_rdata[7:0] = {reload_en_q, 1'b0, sticky, 4'b0000};
      default:   reg_rdata = '0;
    endcase
  end

  // R10: a disabled keyboard-reset edge never becomes a forced event
  a_r10_krst_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q[2]) |-> !force_req);
  // R4: a zero write leaves the counter idle
  a_r4_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tmo && reg_wdata == '0) |=> (cnt == '0 && !wdt_expire));

endmodule

// File: tb/wdt_led_ctrl_tb_top.sv
module wdt_led_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       half_sec_tick = 1'b0;
  logic       mouse_irq = 1'b0, kbd_irq = 1'b0, kbd_rst_in = 1'b0;
  logic       wdt_expire, led_out, led_oe;

  int checks = 0, fails = 0;
  int n_exp = 0, run_len = 0, max_run = 0;
  localparam int TPM = 60;

  always #5 clk = ~clk;

  wdt_led_ctrl #(.TICKS_PER_MIN(TPM), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .half_sec_tick(half_sec_tick),
    .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbd_rst_in(kbd_rst_in),
    .wdt_expire(wdt_expire), .led_out(led_out), .led_oe(led_oe)
  );

  always @(posedge clk) begin
    if (rst_n && wdt_expire) begin
      n_exp <= n_exp + 1;
      run_len = run_len + 1;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); half_sec_tick = 1'b1;
      @(negedge clk); half_sec_tick = 1'b0;
    end
  endtask

  task automatic pulse_in(input int which);
    @(negedge clk);
    if (which == 0) mouse_irq = 1'b1; else if (which == 1) kbd_irq = 1'b1; else kbd_rst_in = 1'b1;
    idle(3);
    mouse_irq = 1'b0; kbd_irq = 1'b0; kbd_rst_in = 1'b0;
    idle(5);
  endtask

  task automatic led_flips(input int n, output int flips);
    logic prev;
    flips = 0;
    idle(2);
    prev = led_out;
    for (int i = 0; i < n; i++) begin
      strobe(1); idle(1);
      if (led_out !== prev) flips++;
      prev = led_out;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog timeout");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int v, e0, fl;
    idle(3); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(2'd0, v); chk("R1 mode reset", v, 0);
    rd(2'd1, v); chk("R1 count reset", v, 0);
    rd(2'd2, v); chk("R1 ctrl reset", v, 0);
    chk("R1 led_oe reset", int'(led_oe), 0);
    chk("R1 expire reset", int'(wdt_expire), 0);
    wr(2'd0, 8'hFF); rd(2'd0, v); chk("R1 mode mask", v, 8'hCC);
    wr(2'd0, 8'h00);

    // R2 sweep of seconds-mode timeouts
    for (int n = 1; n <= 6; n++) begin
      e0 = n_exp;
      wr(2'd1, 8'(n));
      strobe(2 * n - 1); idle(2);
      rd(2'd1, v); chk("R2 count before expiry", v, 1);
      chk("R2 no early expiry", n_exp - e0, 0);
      strobe(1); idle(2);
      chk("R2 expiry at 2N strobes", n_exp - e0, 1);
      rd(2'd1, v); chk("R2 count zero", v, 0);
      rd(2'd2, v); chk("R8 status set", (v >> 4) & 1, 1);
    end
    wr(2'd1, 8'd9); strobe(6); rd(2'd1, v); chk("R2 live count", v, 6);
    rd(2'd2, v); chk("R8 status cleared by write", (v >> 4) & 1, 0);

    // R3 minute mode
    wr(2'd0, 8'h08);
    for (int n = 1; n <= 2; n++) begin
      e0 = n_exp;
      wr(2'd1, 8'(n));
      strobe(2 * TPM * n - 1); idle(2);
      rd(2'd1, v); chk("R3 minute count before expiry", v, 1);
      chk("R3 no early expiry", n_exp - e0, 0);
      strobe(1); idle(2);
      chk("R3 minute expiry", n_exp - e0, 1);
    end
    wr(2'd0, 8'h00);

    // R4 zero disables
    e0 = n_exp;
    wr(2'd1, 8'd4); strobe(3); wr(2'd1, 8'd0); strobe(20); idle(2);
    rd(2'd1, v); chk("R4 count stays zero", v, 0);
    chk("R4 no expiry", n_exp - e0, 0);

    // R5 / R13 reload with keyboard held high, then mouse
    wr(2'd2, 8'hC0);
    e0 = n_exp;
    wr(2'd1, 8'd5); strobe(6);
    rd(2'd1, v); chk("R5 count before reload", v, 2);
    @(negedge clk); kbd_irq = 1'b1; idle(5);
    rd(2'd1, v); chk("R5 kbd reload", v, 5);
    strobe(9); idle(2);
    rd(2'd1, v); chk("R13 held level single reload", v, 1);
    chk("R13 no early expiry", n_exp - e0, 0);
    strobe(1); idle(2);
    chk("R5 expiry after reload", n_exp - e0, 1);
    kbd_irq = 1'b0; idle(4);
    wr(2'd1, 8'd3); strobe(2);
    rd(2'd1, v); chk("R5 count before mouse", v, 2);
    pulse_in(0);
    rd(2'd1, v); chk("R5 mouse reload", v, 3);

    // R6 disabled sources
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd4); strobe(2);
    pulse_in(0); rd(2'd1, v); chk("R6 mouse ignored", v, 3);
    pulse_in(1); rd(2'd1, v); chk("R6 kbd ignored", v, 3);

    // R7 no restart after expiry
    wr(2'd2, 8'hC0);
    e0 = n_exp;
    strobe(6); idle(2);
    chk("R7 expired", n_exp - e0, 1);
    pulse_in(0); pulse_in(1);
    rd(2'd1, v); chk("R7 reload ignored at zero", v, 0);
    strobe(10); idle(2);
    chk("R7 no second expiry", n_exp - e0, 1);

    // R9 forced timeout
    wr(2'd1, 8'd7);
    rd(2'd2, v); chk("R8 status cleared", (v >> 4) & 1, 0);
    wr(2'd0, 8'h04);
    e0 = n_exp;
    pulse_in(2);
    chk("R9 forced expiry", n_exp - e0, 1);
    rd(2'd1, v); chk("R9 count cleared", v, 0);
    rd(2'd2, v); chk("R9 status set", (v >> 4) & 1, 1);

    // R10 keyboard reset ignored when disabled
    wr(2'd0, 8'h00); wr(2'd1, 8'd7);
    e0 = n_exp;
    pulse_in(2);
    chk("R10 no forced expiry", n_exp - e0, 0);
    rd(2'd1, v); chk("R10 count unchanged", v, 7);
    wr(2'd1, 8'd0);

    // R11 / R12 LED patterns
    wr(2'd0, 8'h40); idle(2);
    chk("R11 low mode oe", int'(led_oe), 1);
    chk("R11 low mode level", int'(led_out), 0);
    wr(2'd0, 8'h00); idle(2);
    chk("R11 release oe", int'(led_oe), 0);
    wr(2'd0, 8'h80);
    led_flips(8, fl);
    chk("R12 1Hz flips in 8 strobes", fl, 8);
    chk("R12 fast oe", int'(led_oe), 1);
    wr(2'd0, 8'hC0);
    led_flips(16, fl);
    chk("R12 0.25Hz flips in 16 strobes", fl, 4);

    chk("R8 pulse width", max_run, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule